// File: doc/BRIEF.md
# Indexed-Enable Interrupt Controller

This block is a memory-mapped interrupt controller for a single CPU. It takes 116 level-sensitive main request lines and a second bank of error lines, and drives one interrupt output. Software never edits enable or mask bitmaps directly. To change one source, it writes that source's number to a dedicated set register or a dedicated clear register, so no read-modify-write sequence is needed and two handlers cannot race.

The CPU reads an acknowledge register to get the number of the lowest-numbered source that is enabled, unmasked and requesting. A reserved value in that field means nothing is pending, and the read changes no state. Main source 4 also summarises the error bank. Each error line has its own enable bit in a plain bitmap register. Software is expected to number error bit n as interrupt 116+n once it has read the error cause register. A global enable bit and a one-bit task-priority block sit in front of delivery.

Top module: `idxirq_top`

## Requirements
- R1: After reset, every source is disabled and masked, the global enable and the task-priority block read 0, the error mask reads 0, the acknowledge field reads 0x3FF and irqOut is low.
- R2: Writing a source number to offset 0x30 enables that source. Writing it to offset 0x34 disables it. These registers read as 0.
- R3: Writing a source number to offset 0xB8 masks that source. Writing it to offset 0xBC unmasks it. A source can be acknowledged only while it is both enabled and unmasked.
- R4: A write of a value of 116 or more to any of the four index registers (0x30, 0x34, 0xB8, 0xBC) changes no state.
- R5: Reading offset 0xB4 returns, in bits [9:0], the lowest-numbered source that is requesting, enabled and unmasked. The field is 0x3FF when no such source exists. Bits [31:10] read 0.
- R6: irqOut is high exactly when the acknowledge field is not 0x3FF.
- R7: Bit 0 of offset 0x0 is a global enable. Bit 0 of offset 0xB0 is a task-priority block, where 1 stops delivery. While the global enable is 0 or the block is 1, the acknowledge field is 0x3FF and irqOut is low.
- R8: Main source 4 requests whenever its input line is high or any error line is high with its error-mask bit at 1.
- R9: Offset 0x20 reads the current error lines, with bit n for error line n. Offset 0xEC0 is a read/write bitmap in which a 1 lets the matching error line reach source 4.
- R10: Requests are level-sensitive. A source requests for exactly as long as its input is high, and reading the acknowledge register has no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 12 | Register byte offset for read and write |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for addr (combinational) |
| srcIn | input | 116 | Main request lines, level-sensitive |
| errIn | input | 32 | Error request lines, level-sensitive |
| irqOut | output | 1 | Interrupt request to the CPU |

## Verification
Each main source is first driven alone, one at a time. Its request is then stepped through enable, unmask, mask and disable, which separates the enable gate from the mask gate for every index and catches a mis-decoded index. Sparse random request words and the all-ones word are run with everything enabled, and these show whether the encoder returns the lowest index rather than some other set bit. Out-of-range index writes are chosen to alias in-range numbers if the value is truncated. Error lines are swept one at a time against their mask bits, and the same patterns are also combined with main lines below and above source 4 to show how the summary takes priority.

// File: rtl/idxirq_pkg.sv
package idxirq_pkg;
  localparam int unsigned ADDR_W = 12;

  localparam logic [ADDR_W-1:0] OFS_CTL     = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_ERRSRC  = 12'h020;
  localparam logic [ADDR_W-1:0] OFS_ENSET   = 12'h030;
  localparam logic [ADDR_W-1:0] OFS_ENCLR   = 12'h034;
  localparam logic [ADDR_W-1:0] OFS_TPR     = 12'h0B0;
  localparam logic [ADDR_W-1:0] OFS_ACK     = 12'h0B4;
  localparam logic [ADDR_W-1:0] OFS_MSKSET  = 12'h0B8;
  localparam logic [ADDR_W-1:0] OFS_MSKCLR  = 12'h0BC;
  localparam logic [ADDR_W-1:0] OFS_ERRMSK  = 12'hEC0;

  localparam logic [9:0] NO_IRQ = 10'h3FF;

  typedef struct packed {
    logic enSet;
    logic enClr;
    logic mskSet;
    logic mskClr;
    logic ctlWr;
    logic tprWr;
    logic errMskWr;
  } regStrobe_t;
endpackage

// File: rtl/idxirq_ctrl.sv
module idxirq_ctrl
  import idxirq_pkg::*;
#(
  parameter int unsigned NUM_MAIN = 116
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output regStrobe_t        stb
);
  logic idxOk;
  assign idxOk = wrData < 32'(NUM_MAIN);

  always_comb begin
    stb = '0;
    if (wrEn) begin
      unique case (addr)
        OFS_ENSET:  stb.enSet    = idxOk;
        OFS_ENCLR:  stb.enClr    = idxOk;
        OFS_MSKSET: stb.mskSet   = idxOk;
        OFS_MSKCLR: stb.mskClr   = idxOk;
        OFS_CTL:    stb.ctlWr    = 1'b1;
        OFS_TPR:    stb.tprWr    = 1'b1;
        OFS_ERRMSK: stb.errMskWr = 1'b1;
        default:    stb = '0;
      endcase
    end
  end
endmodule

// File: rtl/idxirq_datapath.sv
module idxirq_datapath
  import idxirq_pkg::*;
#(
  parameter int unsigned NUM_MAIN    = 116,
  parameter int unsigned ERR_W       = 32,
  parameter int unsigned SUMMARY_SRC = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  regStrobe_t          stb,
  input  logic [31:0]         wrData,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [NUM_MAIN-1:0] srcIn,
  input  logic [ERR_W-1:0]    errIn,
  output logic [31:0]         rdData,
  output logic                irqOut
);
  localparam int unsigned IDX_W = $clog2(NUM_MAIN);

  logic [NUM_MAIN-1:0] enBits, unmBits, reqLine, pend;
  logic [ERR_W-1:0]    errMask;
  logic                ctlOn, tprBlock, errSummary, gateOpen;
  logic [9:0]          lowIdx, ackField;
  logic [IDX_W-1:0]    wIdx;

  assign wIdx = wrData[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enBits   <= '0;
      unmBits  <= '0;
      errMask  <= '0;
      ctlOn    <= 1'b0;
      tprBlock <= 1'b0;
    end else begin
      if (stb.enSet)    enBits[wIdx]  <= 1'b1;
      if (stb.enClr)    enBits[wIdx]  <= 1'b0;
      if (stb.mskSet)   unmBits[wIdx] <= 1'b0;
      if (stb.mskClr)   unmBits[wIdx] <= 1'b1;
      if (stb.ctlWr)    ctlOn         <= wrData[0];
      if (stb.tprWr)    tprBlock      <= wrData[0];
      if (stb.errMskWr) errMask       <= wrData[ERR_W-1:0];
    end
  end

  assign errSummary = |(errIn & errMask);

  for (genvar i = 0; i < NUM_MAIN; i++) begin : g_line
    if (i == SUMMARY_SRC) begin : g_sum
      assign reqLine[i] = srcIn[i] | errSummary;
    end else begin : g_plain
      assign reqLine[i] = srcIn[i];
    end
  end

  assign pend     = reqLine & enBits & unmBits;
  assign gateOpen = ctlOn & ~tprBlock;

  always_comb begin
    lowIdx = NO_IRQ;
    for (int i = NUM_MAIN - 1; i >= 0; i--) begin
      if (pend[i]) lowIdx = 10'(i);
    end
  end

  assign ackField = gateOpen ? lowIdx : NO_IRQ;
  assign irqOut   = gateOpen & (|pend);

  always_comb begin
    unique case (addr)
      OFS_CTL:    rdData = {31'b0, ctlOn};
      OFS_TPR:    rdData = {31'b0, tprBlock};
      OFS_ERRSRC: rdData = 32'(errIn);
      OFS_ERRMSK: rdData = 32'(errMask);
      OFS_ACK:    rdData = {22'b0, ackField};
      default:    rdData = '0;
    endcase
  end
endmodule

// File: rtl/idxirq_top.sv
module idxirq_top
  import idxirq_pkg::*;
#(
  parameter int unsigned NUM_MAIN    = 116,
  parameter int unsigned ERR_W       = 32,
  parameter int unsigned SUMMARY_SRC = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [31:0]         wrData,
  output logic [31:0]         rdData,
  input  logic [NUM_MAIN-1:0] srcIn,
  input  logic [ERR_W-1:0]    errIn,
  output logic                irqOut
);
  regStrobe_t stb;

  idxirq_ctrl #(.NUM_MAIN(NUM_MAIN)) u_ctrl (
    .wrEn  (wrEn),
    .addr  (addr),
    .wrData(wrData),
    .stb   (stb)
  );

  idxirq_datapath #(
    .NUM_MAIN   (NUM_MAIN),
    .ERR_W      (ERR_W),
    .SUMMARY_SRC(SUMMARY_SRC)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .stb   (stb),
    .wrData(wrData),
    .addr  (addr),
    .srcIn (srcIn),
    .errIn (errIn),
    .rdData(rdData),
    .irqOut(irqOut)
  );
endmodule

// File: rtl/idxirq_checker.sv
module idxirq_checker
  import idxirq_pkg::*;
#(
  parameter int unsigned NUM_MAIN    = 116,
  parameter int unsigned ERR_W       = 32,
  parameter int unsigned SUMMARY_SRC = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic                wrEn,
  input logic [ADDR_W-1:0]   addr,
  input logic [31:0]         wrData,
  input logic [31:0]         rdData,
  input logic [NUM_MAIN-1:0] srcIn,
  input logic [ERR_W-1:0]    errIn,
  input logic                irqOut
);
  localparam int unsigned IDX_W = $clog2(NUM_MAIN);

  logic ackView;
  assign ackView = (addr == OFS_ACK);

  // R6
  ack_irq_agree_chk: assert property (@(posedge clk) disable iff (!rstN)
    ackView |-> (irqOut == (rdData[9:0] != NO_IRQ)));

  // R5
  ack_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    ackView |-> ((rdData[9:0] == NO_IRQ) || (rdData[9:0] < 10'(NUM_MAIN))) && (rdData[31:10] == '0));

  // R10
  ack_line_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ackView && rdData[9:0] != NO_IRQ && rdData[9:0] != 10'(SUMMARY_SRC))
      |-> srcIn[rdData[IDX_W-1:0]]);

  // R8
  summary_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ackView && rdData[9:0] == 10'(SUMMARY_SRC)) |-> (srcIn[SUMMARY_SRC] || (|errIn)));

  // R7
  global_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == OFS_CTL && !wrData[0]) |=> !irqOut);

  // R7
  tpr_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == OFS_TPR && wrData[0]) |=> !irqOut);
endmodule

bind idxirq_top idxirq_checker #(
  .NUM_MAIN   (NUM_MAIN),
  .ERR_W      (ERR_W),
  .SUMMARY_SRC(SUMMARY_SRC)
) u_chk (
  .clk   (clk),
  .rstN  (rstN),
  .wrEn  (wrEn),
  .addr  (addr),
  .wrData(wrData),
  .rdData(rdData),
  .srcIn (srcIn),
  .errIn (errIn),
  .irqOut(irqOut)
);

// File: tb/test_idxirq_top.sv
module test_idxirq_top;
  localparam int NM = 116;
  localparam int EW = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic [11:0]   addr = '0;
  logic [31:0]   wrData = '0;
  logic [31:0]   rdData;
  logic [NM-1:0] srcIn = '0;
  logic [EW-1:0] errIn = '0;
  logic          irqOut;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  bit          mEn [NM];
  bit          mUnm[NM];
  bit          mCtl, mTpr;
  logic [EW-1:0] mErrMask;

  always #5 clk = ~clk;

  idxirq_top i_idxirq_top (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .srcIn(srcIn), .errIn(errIn), .irqOut(irqOut)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    case (a)
      12'h030: if (d < NM) mEn[d]  = 1'b1;
      12'h034: if (d < NM) mEn[d]  = 1'b0;
      12'h0B8: if (d < NM) mUnm[d] = 1'b0;
      12'h0BC: if (d < NM) mUnm[d] = 1'b1;
      12'h000: mCtl = d[0];
      12'h0B0: mTpr = d[0];
      12'hEC0: mErrMask = d[EW-1:0];
      default: ;
    endcase
  endtask

  task automatic regRead(input logic [11:0] a, output logic [31:0] v);
    addr = a;
    #1;
    v = rdData;
  endtask

  function automatic logic [9:0] expAck();
    if (!mCtl || mTpr) return 10'h3FF;
    for (int i = 0; i < NM; i++) begin
      bit line = srcIn[i];
      if (i == 4) line = line | (|(errIn & mErrMask));
      if (line && mEn[i] && mUnm[i]) return 10'(i);
    end
    return 10'h3FF;
  endfunction

  task automatic chkAck(input string tag);
    logic [31:0] v;
    logic [9:0]  e;
    e = expAck();
    regRead(12'h0B4, v);
    chk(v == {22'b0, e}, tag, v, {22'b0, e});
    chk(irqOut == (e != 10'h3FF), {tag, " irqOut (R6)"}, 32'(irqOut), 32'(e != 10'h3FF));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] v;
    logic [127:0] wide;
    for (int i = 0; i < NM; i++) begin mEn[i] = 0; mUnm[i] = 0; end
    mCtl = 0; mTpr = 0; mErrMask = '0;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    regRead(12'h000, v); chk(v == 0, "R1 ctl reset", v, 0);
    regRead(12'h0B0, v); chk(v == 0, "R1 tpr reset", v, 0);
    regRead(12'hEC0, v); chk(v == 0, "R1 errmask reset", v, 0);
    chkAck("R1 ack reset");
    regWrite(12'h000, 1);
    srcIn = '1;
    chkAck("R1 all disabled with lines high");
    srcIn = '0;

    // R2/R3 per-source sweep
    for (int i = 0; i < NM; i++) begin
      srcIn = '0; srcIn[i] = 1'b1;
      chkAck("R2 line high not enabled");
      regWrite(12'h030, i);
      chkAck("R3 enabled but masked");
      regWrite(12'h0BC, i);
      chkAck("R2 R3 enabled and unmasked");
      regRead(12'h030, v); chk(v == 0, "R2 set reg reads zero", v, 0);
      regWrite(12'h0B8, i);
      chkAck("R3 masked again");
      regWrite(12'h0BC, i);
      regWrite(12'h034, i);
      chkAck("R2 disabled again");
    end

    // R5 priority with all enabled
    for (int i = 0; i < NM; i++) begin
      regWrite(12'h030, i);
      regWrite(12'h0BC, i);
    end
    srcIn = '1;
    chkAck("R5 all lines high");
    for (int k = 0; k < 300; k++) begin
      for (int w = 0; w < 4; w++)
        wide[w*32 +: 32] = $urandom() & $urandom() & $urandom() & $urandom();
      srcIn = wide[NM-1:0];
      chkAck("R5 sparse pattern");
      chkAck("R10 repeated ack read");
    end
    for (int i = NM - 1; i >= 0; i--) begin
      srcIn = '0; srcIn[i] = 1'b1; srcIn[NM-1] = 1'b1;
      chkAck("R5 lowest of two");
    end

    // R10 level behaviour
    srcIn = '0; srcIn[50] = 1'b1;
    chkAck("R10 line held");
    srcIn[50] = 1'b0;
    chkAck("R10 line dropped");

    // R4 out-of-range index writes (243 and 128+2 alias in-range if truncated)
    srcIn = '0; srcIn[115] = 1'b1; srcIn[2] = 1'b1;
    regWrite(12'h034, 243);
    regWrite(12'h0B8, 243);
    regWrite(12'h034, 130);
    regWrite(12'h0B8, 130);
    regWrite(12'h034, 116);
    chkAck("R4 out-of-range clear ignored");
    srcIn[2] = 1'b0;
    chkAck("R4 source 115 still live");
    regWrite(12'h034, 2);
    regWrite(12'h030, 130);
    regWrite(12'h0BC, 130);
    srcIn[2] = 1'b1; srcIn[115] = 1'b0;
    chkAck("R4 out-of-range set ignored");
    regWrite(12'h030, 2);

    // R8/R9 error bank
    srcIn = '0;
    for (int n = 0; n < EW; n++) begin
      errIn = '0; errIn[n] = 1'b1;
      regRead(12'h020, v); chk(v == errIn, "R9 error source readback", v, errIn);
      regWrite(12'hEC0, ~(32'h1 << n));
      chkAck("R8 error line masked off");
      regWrite(12'hEC0, 32'h1 << n);
      regRead(12'hEC0, v); chk(v == (32'h1 << n), "R9 errmask readback", v, 32'h1 << n);
      chkAck("R8 error line reaches source 4");
    end
    errIn = 32'h8000_0001; regWrite(12'hEC0, 32'hFFFF_FFFF);
    srcIn[2] = 1'b1;
    chkAck("R8 lower main beats summary");
    srcIn[2] = 1'b0; srcIn[7] = 1'b1;
    chkAck("R8 summary beats higher main");
    regWrite(12'h034, 4);
    chkAck("R8 summary disabled");
    regWrite(12'h030, 4);
    srcIn = '0; errIn = '0; srcIn[4] = 1'b1;
    chkAck("R8 own line of source 4");
    srcIn = '0; srcIn[9] = 1'b1;

    // R7 gating
    regWrite(12'h000, 0);
    chkAck("R7 global disable");
    regWrite(12'h000, 1);
    chkAck("R7 global re-enable");
    regWrite(12'h0B0, 1);
    regRead(12'h0B0, v); chk(v == 1, "R7 tpr readback", v, 1);
    chkAck("R7 task priority block");
    regWrite(12'h0B0, 0);
    chkAck("R7 task priority release");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule